// File: doc/BRIEF.md
# Quartered Shadow Address Register File

This block stores the pointer registers of a pair of address generators: index, modify, length and base. Each class holds sixteen 32-bit registers. Numbers 0 to 7 serve the first generator (data side) and 8 to 15 serve the second (program side). Every register exists twice, once in a primary bank and once in an alternate bank. The sixteen numbers fall into four quarters of four registers: 0-3, 4-7, 8-11 and 12-15. A four-bit bank-select word carries one bit per quarter, so each quarter can swap to its shadow copy without touching the others. A task switch can then save and restore one quarter while another quarter keeps a value that both contexts use.

Accesses come through two read ports and one write port. Each port is addressed by a class code and a register number. A bank-select write goes through a small per-quarter sequencer. The sequencer has four states: `BK_PRI` (primary in use), `BK_ARM_ALT` (alternate requested, primary still in use), `BK_ALT` (alternate in use) and `BK_ARM_PRI` (primary requested, alternate still in use). A request that changes the bit moves a settled state to its arming state. The arming state moves to the new settled state one cycle later. If another select write arrives while a quarter is arming, the latest value decides the settled state that follows. Reads are combinational from the bank in use in the current cycle. A write lands at the clock edge, in the bank in use during the cycle it was presented.

Top module: `sarf_top`

## Requirements
- R1: After synchronous reset every register of both banks reads zero and every quarter uses its primary bank.
- R2: A write presented in a cycle is returned by a read of the same class and number from the next cycle on. Class codes are 0 index, 1 modify, 2 length, 3 base, and each class and number pair is separate storage.
- R3: The two read ports return data for different addresses in the same cycle, independently of each other.
- R4: Bit k of the bank-select word governs registers 4k to 4k+3 of all four classes: 1 selects the alternate bank and 0 selects the primary bank. Any mix of the four bits is legal.
- R5: Take a select write presented in cycle N that changes a quarter's bit. Reads in cycles N and N+1 still use the old bank, and reads from cycle N+2 on use the new bank.
- R6: Changing one quarter's bit leaves the bank choice and the stored contents of the other three quarters unchanged.
- R7: A bank that is not in use keeps its contents, so switching a quarter back returns its earlier values.
- R8: A select write that repeats the bits already in effect starts no switch and changes no read result.
- R9: A register write presented in the cycle right after a select write goes to the old bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_cls | input | 2 | Class code of the write |
| wr_num | input | 4 | Register number of the write |
| wr_data | input | 32 | Write data |
| mode_we | input | 1 | Bank-select write strobe |
| mode_wdata | input | 4 | New bank-select word, one bit per quarter |
| rd_cls | input | 2x2 | Class code per read port |
| rd_num | input | 2x4 | Register number per read port |
| rd_data | output | 2x32 | Read data per read port |

## Verification
The timing properties assume that a select write arrives only when no quarter is arming. They also assume that after a select write the strobe stays low for at least one cycle. The sequencer accepts back-to-back select writes, but the two-cycle takeover check does not describe that case. The stimulus always follows a select write with at least two cycles without one. This keeps every switch inside what the properties describe, while the reads in the arming cycle and the cycle after it check the latency at the ports.

// File: rtl/sarf_pkg.sv
package sarf_pkg;

    // Register class codes used on the write and read ports
    typedef enum logic [1:0] {
        CLS_IDX  = 2'd0,
        CLS_MOD  = 2'd1,
        CLS_LEN  = 2'd2,
        CLS_BASE = 2'd3
    } reg_cls_e;

    localparam int NUM_CLS = 4;

    // Per-quarter bank sequencer states
    typedef enum logic [1:0] {
        BK_PRI     = 2'd0,
        BK_ARM_ALT = 2'd1,
        BK_ALT     = 2'd2,
        BK_ARM_PRI = 2'd3
    } bank_st_e;

endpackage

// File: rtl/sarf_bank_fsm.sv
module sarf_bank_fsm
    import sarf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_we,
    input  logic req_alt,
    output logic use_alt,
    output logic arming
);

    bank_st_e st_q;
    bank_st_e st_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= BK_PRI;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next state: a changed request arms; arming always settles next cycle
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            BK_PRI: begin
                if (mode_we && req_alt) st_nx = BK_ARM_ALT;
            end
            BK_ARM_ALT: begin
                st_nx = (mode_we && !req_alt) ? BK_PRI : BK_ALT;
            end
            BK_ALT: begin
                if (mode_we && !req_alt) st_nx = BK_ARM_PRI;
            end
            BK_ARM_PRI: begin
                st_nx = (mode_we && req_alt) ? BK_ALT : BK_PRI;
            end
        endcase
    end

    // Outputs: the old bank stays in use while arming
    always_comb begin
        use_alt = 1'b0;
        arming  = 1'b0;
        unique case (st_q)
            BK_PRI:     begin use_alt = 1'b0; arming = 1'b0; end
            BK_ARM_ALT: begin use_alt = 1'b0; arming = 1'b1; end
            BK_ALT:     begin use_alt = 1'b1; arming = 1'b0; end
            BK_ARM_PRI: begin use_alt = 1'b1; arming = 1'b1; end
        endcase
    end

endmodule

// File: rtl/sarf_store.sv
module sarf_store
    import sarf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 16,
    parameter int NGRP = 4,
    parameter int NRD  = 2,
    localparam int NW  = $clog2(NREG),
    localparam int GW  = $clog2(NGRP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NGRP-1:0]          use_alt,
    input  logic                     wr_en,
    input  logic [1:0]               wr_cls,
    input  logic [NW-1:0]            wr_num,
    input  logic [DW-1:0]            wr_data,
    input  logic [NRD-1:0][1:0]      rd_cls,
    input  logic [NRD-1:0][NW-1:0]   rd_num,
    output logic [NRD-1:0][DW-1:0]   rd_data
);

    logic [DW-1:0] mem [NUM_CLS][2][NREG];

    logic [GW-1:0] wr_grp;
    logic          wr_bank;

    assign wr_grp  = wr_num[NW-1 -: GW];
    assign wr_bank = use_alt[wr_grp];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CLS; c++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int r = 0; r < NREG; r++) begin
                        mem[c][b][r] <= '0;
                    end
                end
            end
        end else if (wr_en) begin
            mem[wr_cls][wr_bank][wr_num] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [GW-1:0] rd_grp;
        logic          rd_bank;
        assign rd_grp     = rd_num[p][NW-1 -: GW];
        assign rd_bank    = use_alt[rd_grp];
        assign rd_data[p] = mem[rd_cls[p]][rd_bank][rd_num[p]];
    end

endmodule

// File: rtl/sarf_top.sv
module sarf_top
    import sarf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 16,
    parameter int NGRP = 4,
    parameter int NRD  = 2,
    localparam int NW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [1:0]               wr_cls,
    input  logic [NW-1:0]            wr_num,
    input  logic [DW-1:0]            wr_data,
    input  logic                     mode_we,
    input  logic [NGRP-1:0]          mode_wdata,
    input  logic [NRD-1:0][1:0]      rd_cls,
    input  logic [NRD-1:0][NW-1:0]   rd_num,
    output logic [NRD-1:0][DW-1:0]   rd_data
);

    logic [NGRP-1:0] use_alt;
    logic [NGRP-1:0] arming;

    for (genvar g = 0; g < NGRP; g++) begin : g_quarter
        sarf_bank_fsm u_fsm (
            .clk     (clk),
            .rst     (rst),
            .mode_we (mode_we),
            .req_alt (mode_wdata[g]),
            .use_alt (use_alt[g]),
            .arming  (arming[g])
        );
    end

    sarf_store #(
        .DW   (DW),
        .NREG (NREG),
        .NGRP (NGRP),
        .NRD  (NRD)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .use_alt (use_alt),
        .wr_en   (wr_en),
        .wr_cls  (wr_cls),
        .wr_num  (wr_num),
        .wr_data (wr_data),
        .rd_cls  (rd_cls),
        .rd_num  (rd_num),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/sarf_top_chk.sv
module sarf_top_chk #(
    parameter int NGRP = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            mode_we,
    input logic [NGRP-1:0] mode_wdata,
    input logic [NGRP-1:0] use_alt,
    input logic [NGRP-1:0] arming
);

    // R1: reset leaves every quarter on primary and none arming
    a_r1_reset_primary: assert property (@(posedge clk)
        rst |=> (use_alt == '0 && arming == '0));

    // R5: the cycle after a select write still uses the old banks
    a_r5_old_bank_held: assert property (@(posedge clk) disable iff (rst)
        (mode_we && arming == '0) |=> (use_alt == $past(use_alt)));

    // R5: two cycles after a lone select write the requested banks are in use
    a_r5_new_bank_applied: assert property (@(posedge clk) disable iff (rst)
        (mode_we && arming == '0) ##1 !mode_we |=> (use_alt == $past(mode_wdata, 2)));

    // R6: without a select write and with nothing arming, the choice holds
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!mode_we && arming == '0) |=> $stable(use_alt));

    // R8: repeating the current selection arms nothing
    a_r8_same_value_no_arm: assert property (@(posedge clk) disable iff (rst)
        (mode_we && arming == '0 && mode_wdata == use_alt) |=> (arming == '0));

endmodule

bind sarf_top sarf_top_chk #(.NGRP(NGRP)) u_sarf_top_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .use_alt    (use_alt),
    .arming     (arming)
);

// File: tb/sarf_top_bench.sv
module sarf_top_bench;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [1:0]       wr_cls;
    logic [3:0]       wr_num;
    logic [31:0]      wr_data;
    logic             mode_we;
    logic [3:0]       mode_wdata;
    logic [1:0][1:0]  rd_cls;
    logic [1:0][3:0]  rd_num;
    logic [1:0][31:0] rd_data;

    int vectors = 0;
    int errs    = 0;
    bit done    = 0;

    // Reference model
    logic [31:0] mdl [4][2][16];
    logic [3:0]  bsel;
    logic [3:0]  pend_val;
    int          pend_cnt;

    typedef struct {
        int          port;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sarf_top u_sarf_top (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_cls     (wr_cls),
        .wr_num     (wr_num),
        .wr_data    (wr_data),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .rd_cls     (rd_cls),
        .rd_num     (rd_num),
        .rd_data    (rd_data)
    );

    // Monitor: compare every expectation queued for this cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            vectors++;
            if (rd_data[it.port] !== it.exp) begin
                errs++;
                $display("FAIL %s port %0d got %h expected %h", it.tag, it.port, rd_data[it.port], it.exp);
            end
        end
    end

    function automatic logic [31:0] pat(int bank, int c, int n, int salt);
        return 32'h5A00_0000 ^ (bank << 20) ^ (c << 12) ^ (n << 4) ^ (salt << 24);
    endfunction

    // Advance one clock; update the model the way the requirements say
    task automatic tick();
        @(posedge clk);
        if (!rst && wr_en) mdl[wr_cls][bsel[wr_num >> 2]][wr_num] = wr_data;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) bsel = pend_val;
        end
        #1;
        wr_en   = 1'b0;
        mode_we = 1'b0;
    endtask

    task automatic rd(int p, int c, int n, string tag);
        rd_cls[p] = c[1:0];
        rd_num[p] = n[3:0];
        q.push_back('{p, mdl[c][bsel[n >> 2]][n], tag});
    endtask

    task automatic wr(int c, int n, logic [31:0] d);
        wr_en   = 1'b1;
        wr_cls  = c[1:0];
        wr_num  = n[3:0];
        wr_data = d;
    endtask

    task automatic mode(logic [3:0] v);
        mode_we    = 1'b1;
        mode_wdata = v;
        pend_val   = v;
        pend_cnt   = 2;
    endtask

    task automatic read_all(string tag);
        for (int n = 0; n < 16; n++) begin
            for (int c = 0; c < 4; c += 2) begin
                rd(0, c, n, tag);
                rd(1, c + 1, n, tag);
                tick();
            end
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_cls = 0; wr_num = 0; wr_data = 0;
        mode_we = 0; mode_wdata = 0; rd_cls = '0; rd_num = '0;
        bsel = 4'h0; pend_val = 4'h0; pend_cnt = 0;
        for (int c = 0; c < 4; c++)
            for (int b = 0; b < 2; b++)
                for (int n = 0; n < 16; n++) mdl[c][b][n] = '0;
        tick(); tick(); tick();
        rst = 1'b0;

        // R1: everything reads zero after reset
        read_all("R1");

        // R2: fill the primary bank of every class
        for (int c = 0; c < 4; c++)
            for (int n = 0; n < 16; n++) begin
                wr(c, n, pat(0, c, n, 1));
                tick();
            end
        // R2 / R3: both ports at different addresses in one cycle
        for (int n = 0; n < 16; n++) begin
            rd(0, n % 4, n, "R2");
            rd(1, (n + 1) % 4, 15 - n, "R3");
            tick();
        end

        for (int g = 0; g < 4; g++) begin
            // R5: select write in cycle N, old bank in N and N+1
            mode(bsel ^ (4'b1 << g));
            rd(0, 0, 4 * g, "R5");
            tick();
            rd(0, 1, 4 * g + 1, "R5");
            wr(2, 4 * g + 2, pat(0, 2, 4 * g + 2, 7));   // R9: lands in old bank
            tick();
            rd(0, 2, 4 * g + 2, "R9");
            rd(1, 1, 4 * g + 1, "R5");
            tick();
            // R4: fill the alternate bank of this quarter
            for (int c = 0; c < 4; c++)
                for (int k = 0; k < 4; k++) begin
                    wr(c, 4 * g + k, pat(1, c, 4 * g + k, 3 + g));
                    tick();
                end
            read_all("R6");
            // R7: switch back and find the primary values again
            mode(bsel ^ (4'b1 << g));
            tick(); tick();
            for (int k = 0; k < 4; k++) begin
                rd(0, 0, 4 * g + k, "R7");
                rd(1, 2, 4 * g + k, "R7");
                tick();
                rd(0, 1, 4 * g + k, "R7");
                rd(1, 3, 4 * g + k, "R7");
                tick();
            end
        end

        // R4: mixed selections
        mode(4'b0101); tick(); tick(); read_all("R4");
        mode(4'b1010); tick(); tick(); read_all("R4");
        mode(4'b1111); tick(); tick(); read_all("R4");

        // R8: repeat the selection in effect; reads stay the same
        mode(4'b1111);
        rd(0, 0, 0, "R8"); rd(1, 3, 15, "R8");
        tick();
        rd(0, 1, 5, "R8"); rd(1, 2, 10, "R8");
        tick();
        rd(0, 3, 12, "R8"); rd(1, 0, 3, "R8");
        tick();

        tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule